// File: doc/BRIEF.md
# Infrared Remote-Control Frame Transmitter

This block turns one 8-bit device address and one 8-bit key command into a complete pulse-distance-coded infrared remote-control frame on a single output pin. A one-cycle start strobe, sampled while the block is idle, captures both bytes and raises a busy flag. The frame then plays out. It opens with a long carrier burst followed by a long silence. Next come 32 data bits, each a short burst followed by a short or long silence. A single short burst closes the frame. Busy then drops and the next request can be taken.

The payload holds the address, its bitwise complement, the command and its complement. Each byte goes out low bit first. Every bit value is present exactly once across each byte pair, so the frame lasts the same time whatever the payload. All burst and silence lengths are whole multiples of one base interval of 562.5 us. The base interval and the carrier period are both derived from the system clock frequency parameter. During bursts the pin carries a carrier near 38 kHz with about one-third duty, and it is low whenever no burst is active.

Top module: `nec_ir_tx`

## Requirements
- R1: After reset, and at all times while busy_o is low, ir_o is 0 and busy_o is 0.
- R2: A start_i high at a clock edge while busy_o is low captures addr_i and cmd_i, and busy_o is 1 from the next cycle on.
- R3: The frame opens with 16 base intervals of burst, then 8 base intervals of silence. A base interval is 562.5 us, or CLK_HZ * 562.5e-6 clock cycles rounded to nearest.
- R4: The 32 data bits are, in transmit order: addr bits 0..7, inverted addr bits 0..7, cmd bits 0..7, inverted cmd bits 0..7.
- R5: Each data bit is 1 base interval of burst. It is followed by 1 base interval of silence for a 0, or 3 base intervals of silence for a 1.
- R6: After the 32nd bit, a 1-interval burst is sent. busy_o then falls, so busy_o stays high for exactly 121 base intervals for every payload.
- R7: Within a burst, ir_o repeats with a period of P = round(CLK_HZ/CARRIER_HZ) cycles. It is 1 for the first floor(P/3) cycles of each period and 0 for the rest, with the phase restarting at the first cycle of each burst. During silence ir_o is 0.
- R8: start_i asserted while busy_o is high is ignored: the frame in flight and its length are unchanged, and the new addr_i/cmd_i values are not used.
- R9: A start_i at the first clock edge after busy_o has fallen is accepted, with no idle gap required between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request, sampled while idle |
| addr_i | input | 8 | Device address byte |
| cmd_i | input | 8 | Command byte |
| busy_o | output | 1 | High from the cycle after an accepted request until the frame ends |
| ir_o | output | 1 | Modulated infrared drive, idle low |

## Verification
The assertions assume that reset is asserted before the first edge and that start_i, addr_i and cmd_i are synchronous to clk. They also assume that the clock parameters give a base interval of at least one carrier period. The stimulus meets these conditions. It changes every input only on falling edges and runs the block with a reduced CLK_HZ, so a whole frame spans a few thousand cycles while keeping the same ratios. It also drives a strobe with different data in the middle of a frame, and it requests a new frame on the first idle edge, so the ignore and back-to-back paths are both exercised.

// File: rtl/nec_tx_pkg.sv
`timescale 1ns/1ps
package nec_tx_pkg;

   localparam int unsigned BYTE_W          = 8;
   localparam int unsigned FRAME_BITS      = 4 * BYTE_W;
   localparam int unsigned HDR_MARK_UNITS  = 16;
   localparam int unsigned HDR_SPACE_UNITS = 8;
   localparam int unsigned BIT_MARK_UNITS  = 1;
   localparam int unsigned ZERO_GAP_UNITS  = 1;
   localparam int unsigned ONE_GAP_UNITS   = 3;
   localparam int unsigned TAIL_MARK_UNITS = 1;
   localparam int unsigned UNITS_W         = $clog2(HDR_MARK_UNITS + 1);
   localparam int unsigned BITIDX_W        = $clog2(FRAME_BITS);

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HDR_MARK,
      PH_HDR_SPACE,
      PH_BIT_MARK,
      PH_BIT_SPACE,
      PH_TAIL_MARK
   } tx_phase_e;

   // Transmit order from bit 0 upward: address, ~address, command, ~command
   function automatic logic [FRAME_BITS-1:0] pack_payload(
      input logic [BYTE_W-1:0] dev,
      input logic [BYTE_W-1:0] key
   );
      return {~key, key, ~dev, dev};
   endfunction

   function automatic logic is_burst(input tx_phase_e ph);
      return (ph == PH_HDR_MARK) || (ph == PH_BIT_MARK) || (ph == PH_TAIL_MARK);
   endfunction

endpackage

// File: rtl/nec_unit_timer.sv
`timescale 1ns/1ps
module nec_unit_timer
   import nec_tx_pkg::*;
#(
   parameter int unsigned UNIT_CYC = 28125
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               load,
   input  logic [UNITS_W-1:0] load_units,
   output logic               seg_done
);
   localparam int unsigned CYC_W = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;

   logic [CYC_W-1:0]   cyc_q;
   logic [UNITS_W-1:0] left_q;
   logic               unit_end;

   assign unit_end = (cyc_q == CYC_W'(UNIT_CYC - 1));
   assign seg_done = run && unit_end && (left_q == UNITS_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q  <= '0;
         left_q <= '0;
      end else if (load) begin
         cyc_q  <= '0;
         left_q <= load_units;
      end else if (run) begin
         if (unit_end) begin
            cyc_q  <= '0;
            left_q <= left_q - UNITS_W'(1);
         end else begin
            cyc_q <= cyc_q + CYC_W'(1);
         end
      end
   end

   // R3
   cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_q <= CYC_W'(UNIT_CYC - 1));

   // R6
   left_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load) |-> (left_q != '0));

endmodule

// File: rtl/nec_carrier_gen.sv
`timescale 1ns/1ps
module nec_carrier_gen #(
   parameter int unsigned CAR_CYC  = 1316,
   parameter int unsigned HIGH_CYC = 438
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic carrier_hi
);
   localparam int unsigned PH_W = $clog2(CAR_CYC);

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (restart || (phase_q == PH_W'(CAR_CYC - 1)))
         phase_q <= '0;
      else
         phase_q <= phase_q + PH_W'(1);
   end

   assign carrier_hi = (phase_q < PH_W'(HIGH_CYC));

   // R7
   car_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> carrier_hi);

endmodule

// File: rtl/nec_frame_seq.sv
`timescale 1ns/1ps
module nec_frame_seq
   import nec_tx_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [BYTE_W-1:0]  dev,
   input  logic [BYTE_W-1:0]  key,
   input  logic               seg_done,
   output tx_phase_e          phase,
   output logic               load,
   output logic [UNITS_W-1:0] load_units
);
   tx_phase_e              phase_q, phase_d;
   logic [FRAME_BITS-1:0]  shreg_q;
   logic [BITIDX_W-1:0]    idx_q;

   assign phase = phase_q;

   always_comb begin
      phase_d    = phase_q;
      load       = 1'b0;
      load_units = '0;
      unique case (phase_q)
         PH_IDLE: if (start) begin
            phase_d    = PH_HDR_MARK;
            load       = 1'b1;
            load_units = UNITS_W'(HDR_MARK_UNITS);
         end
         PH_HDR_MARK: if (seg_done) begin
            phase_d    = PH_HDR_SPACE;
            load       = 1'b1;
            load_units = UNITS_W'(HDR_SPACE_UNITS);
         end
         PH_HDR_SPACE: if (seg_done) begin
            phase_d    = PH_BIT_MARK;
            load       = 1'b1;
            load_units = UNITS_W'(BIT_MARK_UNITS);
         end
         PH_BIT_MARK: if (seg_done) begin
            phase_d    = PH_BIT_SPACE;
            load       = 1'b1;
            load_units = shreg_q[0] ? UNITS_W'(ONE_GAP_UNITS) : UNITS_W'(ZERO_GAP_UNITS);
         end
         PH_BIT_SPACE: if (seg_done) begin
            load = 1'b1;
            if (idx_q == BITIDX_W'(FRAME_BITS - 1)) begin
               phase_d    = PH_TAIL_MARK;
               load_units = UNITS_W'(TAIL_MARK_UNITS);
            end else begin
               phase_d    = PH_BIT_MARK;
               load_units = UNITS_W'(BIT_MARK_UNITS);
            end
         end
         PH_TAIL_MARK: if (seg_done) begin
            phase_d = PH_IDLE;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         shreg_q <= '0;
         idx_q   <= '0;
      end else begin
         phase_q <= phase_d;
         if (phase_q == PH_IDLE && start) begin
            shreg_q <= pack_payload(dev, key);
            idx_q   <= '0;
         end else if (phase_q == PH_BIT_SPACE && seg_done) begin
            shreg_q <= {1'b0, shreg_q[FRAME_BITS-1:1]};
            idx_q   <= idx_q + BITIDX_W'(1);
         end
      end
   end

   // R2
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE && start) |=> (phase_q == PH_HDR_MARK));

   // R8
   hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE && start && !seg_done) |=> $stable(shreg_q));

   // R6
   tail_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_TAIL_MARK && $past(phase_q) != PH_TAIL_MARK) |-> (idx_q == '0));

   // R3
   hdr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HDR_SPACE) |-> ($past(phase_q) == PH_HDR_MARK || $past(phase_q) == PH_HDR_SPACE));

endmodule

// File: rtl/nec_ir_tx.sv
`timescale 1ns/1ps
module nec_ir_tx
   import nec_tx_pkg::*;
#(
   parameter int unsigned CLK_HZ     = 50_000_000,
   parameter int unsigned CARRIER_HZ = 38_000,
   parameter int unsigned DUTY_DIV   = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [7:0] addr_i,
   input  logic [7:0] cmd_i,
   output logic       busy_o,
   output logic       ir_o
);
   // base interval 562.5 us, rounded to nearest cycle
   localparam longint unsigned UNIT_L   = (longint'(CLK_HZ) * 5625 + 5_000_000) / 10_000_000;
   localparam int unsigned     UNIT_CYC = int'(UNIT_L);
   localparam int unsigned     CAR_CYC  = (CLK_HZ + CARRIER_HZ / 2) / CARRIER_HZ;
   localparam int unsigned     HIGH_CYC = CAR_CYC / DUTY_DIV;

   generate
      if (UNIT_CYC < 2) begin : g_bad_unit
         $error("base interval shorter than two clock cycles");
      end
      if (CAR_CYC < 3 || HIGH_CYC < 1) begin : g_bad_car
         $error("carrier period too short for the requested duty");
      end
      if (UNIT_CYC < CAR_CYC) begin : g_bad_ratio
         $error("base interval shorter than one carrier period");
      end
      if (DUTY_DIV < 2) begin : g_bad_duty
         $error("duty divider must be at least 2");
      end
   endgenerate

   tx_phase_e          phase;
   logic               load;
   logic [UNITS_W-1:0] load_units;
   logic               seg_done;
   logic               carrier_hi;
   logic               in_burst;

   nec_frame_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_i),
      .dev        (addr_i),
      .key        (cmd_i),
      .seg_done   (seg_done),
      .phase      (phase),
      .load       (load),
      .load_units (load_units)
   );

   nec_unit_timer #(.UNIT_CYC(UNIT_CYC)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (busy_o),
      .load       (load),
      .load_units (load_units),
      .seg_done   (seg_done)
   );

   nec_carrier_gen #(.CAR_CYC(CAR_CYC), .HIGH_CYC(HIGH_CYC)) u_car (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (load),
      .carrier_hi (carrier_hi)
   );

   assign busy_o   = (phase != PH_IDLE);
   assign in_burst = is_burst(phase);
   assign ir_o     = in_burst & carrier_hi;

   // R1
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !ir_o);

   // R7
   space_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HDR_SPACE || phase == PH_BIT_SPACE) |-> !ir_o);

   // R9
   end_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TAIL_MARK && seg_done) |=> !busy_o);

endmodule

// File: tb/tb_nec_ir_tx.sv
`timescale 1ns/1ps
module tb_nec_ir_tx;
   // Reduced clock frequency parameter keeps a frame short:
   // 64000 Hz * 562.5 us = 36 cycles per base interval,
   // carrier period 64000/8000 = 8 cycles, high for 8/3 = 2 cycles.
   localparam int unsigned TB_CLK_HZ = 64_000;
   localparam int unsigned TB_CAR_HZ = 8_000;
   localparam int UNIT  = 36;
   localparam int CARP  = 8;
   localparam int CHIGH = 2;
   localparam int FRAME_UNITS = 121;

   localparam logic [15:0] VEC_TAB [0:5] = '{
      16'h00_00, 16'hFF_FF, 16'hA5_3C, 16'h01_80, 16'h7E_12, 16'hC3_F0
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] addr_i = '0;
   logic [7:0] cmd_i = '0;
   logic       busy_o;
   logic       ir_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   nec_ir_tx #(.CLK_HZ(TB_CLK_HZ), .CARRIER_HZ(TB_CAR_HZ)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
      .cmd_i(cmd_i), .busy_o(busy_o), .ir_o(ir_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Called at a falling edge while idle; returns at the falling edge after the frame.
   task automatic run_frame(input logic [7:0] a, input logic [7:0] c, input bit inject);
      logic [31:0] pl;
      int lead_err = 0, data_err = 0, stop_err = 0, car_err = 0, busy_err = 0;
      int first_busy = 0;
      pl = {~c, c, ~a, a};
      addr_i = a; cmd_i = c; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      addr_i = 8'h5A; cmd_i = 8'hA5;
      for (int s = 0; s < 67; s++) begin
         int mark, units;
         if (s == 0) begin mark = 1; units = 16; end
         else if (s == 1) begin mark = 0; units = 8; end
         else if (s == 66) begin mark = 1; units = 1; end
         else if (((s - 2) % 2) == 0) begin mark = 1; units = 1; end
         else begin mark = 0; units = pl[(s - 2) / 2] ? 3 : 1; end
         for (int o = 0; o < units * UNIT; o++) begin
            int expv;
            if (inject && s == 10 && o == 0) begin
               start_i = 1'b1; addr_i = ~a; cmd_i = ~c;
            end else if (inject && s == 10 && o == 1) begin
               start_i = 1'b0;
            end
            expv = (mark != 0 && (o % CARP) < CHIGH) ? 1 : 0;
            if (s == 0 && o == 0) first_busy = busy_o;
            if (int'(ir_o) != expv) begin
               if (mark != 0) car_err++;
               if (s < 2) lead_err++;
               else if (s == 66) stop_err++;
               else data_err++;
            end
            if (busy_o !== 1'b1) busy_err++;
            @(negedge clk);
         end
      end
      check(first_busy == 1, "R2/R9 busy in first cycle", first_busy, 1);
      check(lead_err == 0, "R3 header mismatching cycles", lead_err, 0);
      check(data_err == 0, "R4/R5 data mismatching cycles", data_err, 0);
      check(car_err == 0, "R7 burst carrier mismatching cycles", car_err, 0);
      check(stop_err == 0 && busy_err == 0, "R6 tail/busy mismatching cycles",
            stop_err + busy_err, 0);
      check(busy_o == 1'b0 && ir_o == 1'b0, "R6 busy falls after 121 intervals",
            int'(busy_o), 0);
      if (inject)
         check(lead_err + data_err + stop_err + busy_err == 0, "R8 mid-frame start ignored",
               lead_err + data_err + stop_err + busy_err, 0);
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      check(busy_o == 1'b0, "R1 busy in reset", int'(busy_o), 0);
      check(ir_o == 1'b0, "R1 ir in reset", int'(ir_o), 0);
      rst_n = 1'b1;
      begin
         int hi = 0;
         for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (ir_o || busy_o) hi++;
         end
         check(hi == 0, "R1 idle low after reset", hi, 0);
      end
      // table walk: frames run back to back (R9)
      for (int v = 0; v < 6; v++)
         run_frame(VEC_TAB[v][15:8], VEC_TAB[v][7:0], 1'b0);
      // directed: strobe with other data during a frame (R8)
      repeat (5) @(negedge clk);
      run_frame(8'h3C, 8'hC6, 1'b1);
      // directed: idle after frame stays low (R1)
      begin
         int hi = 0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (ir_o || busy_o) hi++;
         end
         check(hi == 0, "R1 idle low after frame", hi, 0);
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : watchdog
      repeat (150_000) @(posedge clk);
      if (!done) begin
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
         $finish;
      end
   end

endmodule